// File: doc/BRIEF.md
# 4B/5B Symbol Path with Translational and Transparent Modes

This block sits between the 5-bit code-group side of a 100 Mb/s physical coding layer and a nibble-wide MII. It has two modes.

In translational mode it converts data in both directions with the usual 4B/5B code. On transmit it puts the start and end stream delimiters around a frame. On receive it replaces the start delimiter with preamble nibbles and removes the end delimiter.

In transparent mode, meant for repeater controllers, the symbol crosses the nibble bus unchanged. The four low bits travel on the data lines and the fifth bit travels on the error line. Delimiters pass through untouched, and the idle code group crosses the MII as all zeros.

A two-bit loopback selector adds two diagnostic paths. One turns transmitted symbols back into the receive path. The other echoes received symbols straight back out of the transmitter. A repeater input keeps the block's own transmission from raising carrier sense.

Symbol codes used throughout: J=11000, K=10001, T=01101, R=00111, idle=11111, transmit error H=00100. Data nibbles 0..F map to 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101. Mode input `transparent` is 1 for transparent mode and 0 for translational mode.

Top module: `sym5_mii_path`

## Requirements
- R1: In translational mode, the clock edge that first sees tx_en high emits J on tx_sym and the next edge emits K, whatever txd holds in those two cycles. Each later edge with tx_en high emits the 5-bit code of txd.
- R2: In translational mode, an edge with tx_en and tx_er both high emits H (00100). The first edge after tx_en falls emits T, the next emits R, and idle (11111) follows.
- R3: In translational mode, a received J followed by K produces two output nibbles of 0101 with rx_dv high and rx_er low. Each data code group that follows is output as its decoded nibble with rx_dv high.
- R4: A received T inside a frame drops rx_dv on that symbol, and the R after it keeps rx_dv low. Neither symbol appears as data.
- R5: In translational mode, a received symbol inside a frame that is neither a data code nor T sets rx_er with rx_dv high for that nibble; 00000 is such a symbol. An idle symbol inside a frame does the same and ends the frame.
- R6: In transparent mode, each received symbol appears with bits 3:0 on rxd and bit 4 on rx_er, and an idle symbol appears as rxd=0, rx_er=0. rx_dv rises on J and falls on T exactly as in translational mode.
- R7: In transparent mode, tx_sym is {tx_er, txd} one edge later and no delimiters are added. The all-zero value is sent as idle 11111.
- R8: Reset clears rxd, rx_dv, rx_er and crs to 0 and sets tx_sym to idle. The receive outputs change only on edges where a symbol is valid, and they hold otherwise.
- R9: lb_sel=10 selects PMD loopback: the receive path takes the transmitted symbols and ignores rx_sym. lb_sel=01 selects remote loopback: tx_sym repeats rx_sym one edge later. lb_sel=00 or 11 is normal operation.
- R10: crs is high one edge after the receive path is inside a frame, or after an edge that sees tx_en high when repeater is 0. When repeater is 1, tx_en alone never raises crs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst | input | 1 | Synchronous active-high reset |
| transparent | input | 1 | 1 = transparent mode, 0 = translational mode |
| repeater | input | 1 | 1 = own transmission does not raise crs |
| lb_sel | input | 2 | Loopback select: 10 PMD, 01 remote, others normal |
| rx_sym | input | 5 | Received code group |
| rx_sym_vld | input | 1 | rx_sym is valid this cycle |
| tx_en | input | 1 | MII transmit enable |
| tx_er | input | 1 | MII transmit error, or symbol bit 4 in transparent mode |
| txd | input | 4 | MII transmit nibble |
| rxd | output | 4 | MII receive nibble |
| rx_dv | output | 1 | MII receive data valid |
| rx_er | output | 1 | MII receive error, or symbol bit 4 in transparent mode |
| crs | output | 1 | Carrier sense |
| tx_sym | output | 5 | Transmitted code group |

## Verification
The assertions assume that mode and loopback selection stay fixed while a frame is in flight in either direction. They also assume that each valid receive strobe carries exactly one code group. The stimulus changes `transparent`, `lb_sel` and `repeater` only between scenarios, after a flush. A flush drops tx_en for several cycles and feeds idle symbols, so that both state machines are back in their idle state before any selection changes.

// File: rtl/sym5_pkg.sv
package sym5_pkg;
  localparam int SYM_W = 5;
  localparam int NIB_W = 4;

  localparam logic [SYM_W-1:0] SYM_J    = 5'b11000;
  localparam logic [SYM_W-1:0] SYM_K    = 5'b10001;
  localparam logic [SYM_W-1:0] SYM_T    = 5'b01101;
  localparam logic [SYM_W-1:0] SYM_R    = 5'b00111;
  localparam logic [SYM_W-1:0] SYM_IDLE = 5'b11111;
  localparam logic [SYM_W-1:0] SYM_H    = 5'b00100;
  localparam logic [NIB_W-1:0] NIB_PRE  = 4'b0101;

  typedef enum logic [1:0] {RX_IDLE, RX_GOT_J, RX_FRAME, RX_GOT_T} rx_st_t;
  typedef enum logic [1:0] {TX_IDLE, TX_SEND_K, TX_DATA, TX_SEND_R} tx_st_t;

  function automatic logic [SYM_W-1:0] enc4b5b(input logic [NIB_W-1:0] n);
    case (n)
      4'h0: enc4b5b = 5'b11110;  4'h1: enc4b5b = 5'b01001;
      4'h2: enc4b5b = 5'b10100;  4'h3: enc4b5b = 5'b10101;
      4'h4: enc4b5b = 5'b01010;  4'h5: enc4b5b = 5'b01011;
      4'h6: enc4b5b = 5'b01110;  4'h7: enc4b5b = 5'b01111;
      4'h8: enc4b5b = 5'b10010;  4'h9: enc4b5b = 5'b10011;
      4'hA: enc4b5b = 5'b10110;  4'hB: enc4b5b = 5'b10111;
      4'hC: enc4b5b = 5'b11010;  4'hD: enc4b5b = 5'b11011;
      4'hE: enc4b5b = 5'b11100;  default: enc4b5b = 5'b11101;
    endcase
  endfunction

  // returns {valid, nibble}
  function automatic logic [NIB_W:0] dec5b4b(input logic [SYM_W-1:0] s);
    dec5b4b = '0;
    for (int i = 0; i < (1 << NIB_W); i++) begin
      if (enc4b5b(NIB_W'(i)) == s) dec5b4b = {1'b1, NIB_W'(i)};
    end
  endfunction
endpackage

// File: rtl/sym5_rx_path.sv
module sym5_rx_path
  import sym5_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             transp,
  input  logic [SYM_W-1:0] sym,
  input  logic             vld,
  output logic [NIB_W-1:0] rxd,
  output logic             rx_dv,
  output logic             rx_er,
  output logic             active
);
  rx_st_t           st, st_n;
  logic [NIB_W-1:0] nib_n;
  logic             dv_n, er_n;
  logic [NIB_W:0]   dec;

  assign dec    = dec5b4b(sym);
  assign active = (st != RX_IDLE);

  always_comb begin
    st_n  = st;
    nib_n = '0;
    dv_n  = 1'b0;
    er_n  = 1'b0;
    case (st)
      RX_IDLE: if (sym == SYM_J) begin
        st_n = RX_GOT_J; dv_n = 1'b1; nib_n = NIB_PRE;
      end
      RX_GOT_J: begin
        dv_n = 1'b1;
        if (sym == SYM_K) begin
          st_n = RX_FRAME; nib_n = NIB_PRE;
        end else begin
          st_n = RX_IDLE; er_n = 1'b1;
        end
      end
      RX_FRAME: begin
        if (sym == SYM_T) begin
          st_n = RX_GOT_T;
        end else if (sym == SYM_IDLE) begin
          st_n = RX_IDLE; dv_n = 1'b1; er_n = 1'b1;
        end else begin
          dv_n  = 1'b1;
          er_n  = ~dec[NIB_W];
          nib_n = dec[NIB_W] ? dec[NIB_W-1:0] : '0;
        end
      end
      default: st_n = RX_IDLE;
    endcase
    if (transp) begin
      nib_n = (sym == SYM_IDLE) ? '0 : sym[NIB_W-1:0];
      er_n  = (sym == SYM_IDLE) ? 1'b0 : sym[SYM_W-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= RX_IDLE; rxd <= '0; rx_dv <= 1'b0; rx_er <= 1'b0;
    end else if (vld) begin
      st <= st_n; rxd <= nib_n; rx_dv <= dv_n; rx_er <= er_n;
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !vld |=> $stable({rxd, rx_dv, rx_er}));
  p_transp_map_r6: assert property (@(posedge clk) disable iff (rst)
    (transp && vld && sym != SYM_IDLE) |=> ({rx_er, rxd} == $past(sym)));
  p_dv_on_j_r3: assert property (@(posedge clk) disable iff (rst)
    (vld && !active && sym == SYM_J) |=> rx_dv);
endmodule

// File: rtl/sym5_tx_path.sv
module sym5_tx_path
  import sym5_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             transp,
  input  logic             tx_en,
  input  logic             tx_er,
  input  logic [NIB_W-1:0] txd,
  output logic [SYM_W-1:0] tx_sym
);
  tx_st_t           st, st_n;
  logic [SYM_W-1:0] sym_n;
  logic [SYM_W-1:0] raw;

  assign raw = {tx_er, txd};

  always_comb begin
    st_n  = st;
    sym_n = SYM_IDLE;
    if (transp) begin
      st_n  = TX_IDLE;
      sym_n = (raw == '0) ? SYM_IDLE : raw;
    end else begin
      case (st)
        TX_IDLE: if (tx_en) begin
          st_n = TX_SEND_K; sym_n = SYM_J;
        end
        TX_SEND_K: begin
          st_n = TX_DATA; sym_n = SYM_K;
        end
        TX_DATA: if (tx_en) begin
          sym_n = tx_er ? SYM_H : enc4b5b(txd);
        end else begin
          st_n = TX_SEND_R; sym_n = SYM_T;
        end
        default: begin
          st_n = TX_IDLE; sym_n = SYM_R;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= TX_IDLE; tx_sym <= SYM_IDLE;
    end else begin
      st <= st_n; tx_sym <= sym_n;
    end
  end

  p_t_then_r_r2: assert property (@(posedge clk) disable iff (rst)
    (!transp && tx_sym == SYM_T) |=> (transp || tx_sym == SYM_R));
  p_transp_tx_r7: assert property (@(posedge clk) disable iff (rst)
    (transp && raw != '0) |=> (tx_sym == $past(raw)));
endmodule

// File: rtl/sym5_mii_path.sv
module sym5_mii_path
  import sym5_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             transparent,
  input  logic             repeater,
  input  logic [1:0]       lb_sel,
  input  logic [SYM_W-1:0] rx_sym,
  input  logic             rx_sym_vld,
  input  logic             tx_en,
  input  logic             tx_er,
  input  logic [NIB_W-1:0] txd,
  output logic [NIB_W-1:0] rxd,
  output logic             rx_dv,
  output logic             rx_er,
  output logic             crs,
  output logic [SYM_W-1:0] tx_sym
);
  logic             pmd_lb, remote_lb, rx_active;
  logic [SYM_W-1:0] enc_sym, echo_q, rx_in;
  logic             rx_in_vld;

  assign pmd_lb    = (lb_sel == 2'b10);
  assign remote_lb = (lb_sel == 2'b01);
  assign rx_in     = pmd_lb ? enc_sym : rx_sym;
  assign rx_in_vld = pmd_lb | rx_sym_vld;

  sym5_tx_path u_tx (
    .clk(clk), .rst(rst), .transp(transparent),
    .tx_en(tx_en), .tx_er(tx_er), .txd(txd), .tx_sym(enc_sym)
  );

  sym5_rx_path u_rx (
    .clk(clk), .rst(rst), .transp(transparent),
    .sym(rx_in), .vld(rx_in_vld),
    .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er), .active(rx_active)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      echo_q <= SYM_IDLE;
      crs    <= 1'b0;
    end else begin
      echo_q <= rx_sym;
      crs    <= rx_active | (tx_en & ~repeater);
    end
  end

  assign tx_sym = remote_lb ? echo_q : enc_sym;

  p_remote_echo_r9: assert property (@(posedge clk) disable iff (rst)
    (lb_sel == 2'b01) |=> (lb_sel != 2'b01 || tx_sym == $past(rx_sym)));
  p_rep_crs_r10: assert property (@(posedge clk) disable iff (rst)
    (repeater && !rx_active) |=> !crs);
endmodule

// File: tb/sym5_mii_path_bench.sv
`timescale 1ns/1ps
module sym5_mii_path_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       transparent, repeater;
  logic [1:0] lb_sel;
  logic [4:0] rx_sym;
  logic       rx_sym_vld, tx_en, tx_er;
  logic [3:0] txd;
  logic [3:0] rxd;
  logic       rx_dv, rx_er, crs;
  logic [4:0] tx_sym;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  sym5_mii_path u_sym5_mii_path (
    .clk(clk), .rst(rst), .transparent(transparent), .repeater(repeater),
    .lb_sel(lb_sel), .rx_sym(rx_sym), .rx_sym_vld(rx_sym_vld),
    .tx_en(tx_en), .tx_er(tx_er), .txd(txd),
    .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er), .crs(crs), .tx_sym(tx_sym)
  );

  function automatic logic [4:0] code(input logic [3:0] n);
    logic [4:0] tbl [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                             5'b01010, 5'b01011, 5'b01110, 5'b01111,
                             5'b10010, 5'b10011, 5'b10110, 5'b10111,
                             5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return tbl[n];
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rx_put(input logic [4:0] s);
    rx_sym = s; rx_sym_vld = 1'b1; step();
  endtask

  task automatic flush();
    tx_en = 0; tx_er = 0; txd = 0; rx_sym = 5'b11111; rx_sym_vld = 1;
    repeat (5) step();
  endtask

  task automatic t_reset();
    chk("R8 reset rx", {rxd, rx_dv, rx_er}, 0);
    chk("R8 reset crs", crs, 0);
    chk("R8 reset tx idle", tx_sym, 5'b11111);
  endtask

  task automatic t_tx_trans();
    tx_en = 1; txd = 4'h5; step();
    chk("R1 J first", tx_sym, 5'b11000);
    step();
    chk("R1 K second", tx_sym, 5'b10001);
    txd = 4'hA; step();
    chk("R1 data A", tx_sym, code(4'hA));
    txd = 4'h0; step();
    chk("R1 data 0", tx_sym, code(4'h0));
    tx_er = 1; step();
    chk("R2 H on tx_er", tx_sym, 5'b00100);
    tx_er = 0; tx_en = 0; step();
    chk("R2 T after end", tx_sym, 5'b01101);
    step();
    chk("R2 R after T", tx_sym, 5'b00111);
    step();
    chk("R2 idle after R", tx_sym, 5'b11111);
    flush();
  endtask

  task automatic t_rx_trans();
    rx_put(5'b11000);
    chk("R3 J->5 dv", {rx_dv, rx_er, rxd}, 6'b10_0101);
    rx_put(5'b10001);
    chk("R3 K->5 dv", {rx_dv, rx_er, rxd}, 6'b10_0101);
    rx_put(code(4'h3));
    chk("R3 data 3", {rx_dv, rx_er, rxd}, 6'b10_0011);
    rx_put(5'b00000);
    chk("R5 invalid sets er", {rx_dv, rx_er}, 2'b11);
    rx_put(code(4'hC));
    chk("R3 data C", {rx_dv, rx_er, rxd}, 6'b10_1100);
    rx_put(5'b01101);
    chk("R4 T drops dv", rx_dv, 0);
    rx_put(5'b00111);
    chk("R4 R keeps dv low", {rx_dv, rx_er}, 0);
    rx_put(5'b11111);
    chk("R4 idle after frame", rx_dv, 0);
    rx_put(5'b11000); rx_put(5'b10001);
    rx_put(5'b11111);
    chk("R5 idle in frame er", {rx_dv, rx_er}, 2'b11);
    rx_put(5'b11111);
    chk("R5 frame ended", rx_dv, 0);
    flush();
  endtask

  task automatic t_hold();
    rx_put(5'b11000); rx_put(5'b10001); rx_put(code(4'h7));
    rx_sym = 5'b01101; rx_sym_vld = 0; step(); step();
    chk("R8 hold without vld", {rx_dv, rx_er, rxd}, 6'b10_0111);
    flush();
  endtask

  task automatic t_rx_transp();
    transparent = 1;
    rx_put(5'b11111);
    chk("R6 idle as zero", {rx_dv, rx_er, rxd}, 0);
    rx_put(5'b11000);
    chk("R6 J raw dv", {rx_dv, rx_er, rxd}, 6'b11_1000);
    rx_put(5'b10001);
    chk("R6 K raw", {rx_dv, rx_er, rxd}, 6'b11_0001);
    rx_put(5'b01110);
    chk("R6 data raw", {rx_dv, rx_er, rxd}, 6'b10_1110);
    rx_put(5'b01101);
    chk("R6 T raw dv low", {rx_dv, rx_er, rxd}, 6'b00_1101);
    rx_put(5'b00111);
    chk("R6 R raw", {rx_dv, rx_er, rxd}, 6'b00_0111);
    flush();
    transparent = 0;
    flush();
  endtask

  task automatic t_tx_transp();
    transparent = 1;
    tx_en = 1; tx_er = 1; txd = 4'b1000; step();
    chk("R7 raw J", tx_sym, 5'b11000);
    tx_er = 0; txd = 4'b0111; step();
    chk("R7 raw R", tx_sym, 5'b00111);
    txd = 4'b0000; step();
    chk("R7 zero as idle", tx_sym, 5'b11111);
    flush();
    transparent = 0;
    flush();
  endtask

  task automatic t_pmd_lb();
    lb_sel = 2'b10; rx_sym = 5'b00000; rx_sym_vld = 1;
    tx_en = 1; txd = 4'h5; step();
    step();
    chk("R9 pmd J looped", {rx_dv, rx_er, rxd}, 6'b10_0101);
    txd = 4'h9; step();
    step();
    chk("R9 pmd data looped", {rx_dv, rx_er, rxd}, 6'b10_1001);
    flush();
    lb_sel = 2'b00;
    flush();
  endtask

  task automatic t_remote_lb();
    lb_sel = 2'b01;
    rx_put(code(4'h3));
    chk("R9 remote echo 1", tx_sym, code(4'h3));
    rx_put(code(4'h1));
    chk("R9 remote echo 2", tx_sym, code(4'h1));
    lb_sel = 2'b11;
    rx_put(code(4'h3));
    chk("R9 11 is normal", tx_sym, 5'b11111);
    lb_sel = 2'b00;
    flush();
  endtask

  task automatic t_crs();
    repeater = 0; tx_en = 1; step();
    chk("R10 node tx crs", crs, 1);
    flush();
    repeater = 1; tx_en = 1; step(); step();
    chk("R10 repeater no tx crs", crs, 0);
    rx_put(5'b11000); rx_put(5'b10001);
    chk("R10 repeater rx crs", crs, 1);
    flush();
    repeater = 0;
    flush();
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1; transparent = 0; repeater = 0; lb_sel = 2'b00;
    rx_sym = 5'b11111; rx_sym_vld = 0; tx_en = 0; tx_er = 0; txd = 0;
    #1; repeat (3) step();
    rst = 0;
    t_reset();
    flush();
    t_tx_trans();
    t_rx_trans();
    t_hold();
    t_rx_transp();
    t_tx_transp();
    t_pmd_lb();
    t_remote_lb();
    t_crs();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule